// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits at the issue stage of a two-wide in-order pipeline. Each cycle it receives two consecutive instructions that are already decoded, called slot 0 (older) and slot 1 (younger). It decides whether slot 1 may issue in the same cycle as slot 0. The decision uses four inputs. The first is an asymmetric table of class pairs, keyed on which instruction comes first. The second is a set of register and floating-point register-half conflicts. The third is the carry/borrow flag usage of both slots. The fourth is a set of context rules: branch delay slots, odd word addresses, and taken-branch targets.

The result is a `pair_ok` bit plus a reason code that names the first rule that blocked the pair. The issue logic uses `pair_ok` to send both instructions, or only slot 0. The reason code feeds performance analysis and debug. By default the result is registered. A parameter selects a purely combinational variant.

Top module: `pair_gate`

## Requirements
- R1: Class codes are 0 FP op, 1 load/store, 2 integer ALU, 3 shift/extract/deposit, 4 may-nullify, 5 register-indirect branch, 6 other branch, 7 FP test/status, 8 system control. A system-control instruction in either slot never pairs. Codes 9 to 15 never pair.
- R2: If slot 0 is an FP op, slot 1 may be class 1, 2, 3, 4, 5 or 6. If slot 0 is a load/store, slot 1 may be class 0, 2, 3, 4 or 6, so a register-indirect branch is refused.
- R3: If slot 0 is an integer ALU op, slot 1 may be class 0, 1, 2, 3, 4, 6 or 7. If slot 0 is shift/extract/deposit, slot 1 may be class 0, 1, 2 or 7. If slot 0 is class 4, slot 1 may be class 0 only. A slot-0 class of 5, 6 or 7 never pairs.
- R4: When `s0_may_nul` is high, slot 1 must be an FP op, whatever the slot-0 class.
- R5: An operand field is laid out as {valid, fp, half, num}: bit REG_W+2 is valid, bit REG_W+1 selects the FP file, bit REG_W selects the word half, and the low REG_W bits hold the register number. A dependency exists when the slot-0 destination and a slot-1 source are both valid, are in the same file, have equal numbers, and have equal halves if they are FP. A destination whose number is 0 never creates a dependency. A dependency refuses the pair.
- R6: Slot 0 may be an FP op and slot 1 an FP store (class 1 with `s1_store` high) whose data source `s1_srcb` is that op's result. This one dependency is excused. A match on `s1_srca` still refuses the pair.
- R7: Take an FP load (class 1, store flag low, FP destination) in either slot and an FP op in the other slot. If the FP op reads the other half of the same nonzero doubleword, the pair is refused.
- R8: An FP op and an FP load in opposite slots whose FP destinations name the same nonzero register and half are refused.
- R9: A carry/borrow setter in one slot together with a carry/borrow user in the other slot is refused, in either order.
- R10: The pair is refused when slot 0 is at an odd word address, when either slot is in a branch delay slot, or when slot 1 is reached as a taken-branch target.
- R11: `why` gives 0 when the pair is allowed. Otherwise it gives the first blocking rule, checked in this order: 1 context, 2 class (including R1 and R4), 3 register dependency, 4 FP doubleword/target conflict, 5 carry.
- R12: With REG_OUT=1 the outputs reflect the inputs sampled at the previous rising edge. A synchronous active-high reset drives `pair_ok` to 0 and `why` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_cls | input | 4 | Slot-0 class code |
| s0_dst | input | REG_W+3 | Slot-0 destination operand |
| s0_srca | input | REG_W+3 | Slot-0 first source operand |
| s0_srcb | input | REG_W+3 | Slot-0 second source operand |
| s0_store | input | 1 | Slot-0 memory op is a store |
| s0_cb_set | input | 1 | Slot 0 may set carry/borrow |
| s0_cb_use | input | 1 | Slot 0 reads carry/borrow |
| s0_may_nul | input | 1 | Slot 0 may nullify its successor |
| s0_odd | input | 1 | Slot 0 is at an odd word address |
| s0_dslot | input | 1 | Slot 0 is in a branch delay slot |
| s1_cls | input | 4 | Slot-1 class code |
| s1_dst | input | REG_W+3 | Slot-1 destination operand |
| s1_srca | input | REG_W+3 | Slot-1 first source (store base) |
| s1_srcb | input | REG_W+3 | Slot-1 second source (store data) |
| s1_store | input | 1 | Slot-1 memory op is a store |
| s1_cb_set | input | 1 | Slot 1 may set carry/borrow |
| s1_cb_use | input | 1 | Slot 1 reads carry/borrow |
| s1_dslot | input | 1 | Slot 1 is in a branch delay slot |
| s1_tgt | input | 1 | Slot 1 reached as a taken-branch target |
| pair_ok | output | 1 | Slot 1 may issue with slot 0 |
| why | output | 3 | Blocking reason code |

## Verification
The class table is covered from both sides. Pairs that only one row admits show the asymmetry: an FP op then a register-indirect branch pairs, but a load/store then a register-indirect branch does not. Register patterns separate a real dependency from three look-alikes: a destination numbered 0, an invalid field, and a read of the opposite FP half. They also separate the excused FP-op-to-store-data case from a match on the store base. Stacked violations, such as context plus system class or a dependency plus a carry conflict, confirm the reported priority. A long random stream is compared against a behavioural model on every clock to catch wrong interactions between rules.

// File: rtl/pair_pkg.sv
package pair_pkg;
   localparam int CLS_W = 4;

   typedef enum logic [CLS_W-1:0] {
      CL_FPOP = 4'd0,
      CL_MEM  = 4'd1,
      CL_ALU  = 4'd2,
      CL_SHX  = 4'd3,
      CL_NULF = 4'd4,
      CL_JIND = 4'd5,
      CL_JMP  = 4'd6,
      CL_FCHK = 4'd7,
      CL_SYS  = 4'd8
   } cls_e;

   typedef enum logic [2:0] {
      RS_NONE  = 3'd0,
      RS_CTX   = 3'd1,
      RS_CLASS = 3'd2,
      RS_DEP   = 3'd3,
      RS_FPDW  = 3'd4,
      RS_CARRY = 3'd5
   } reason_e;
endpackage

// File: rtl/pair_class_matrix.sv
module pair_class_matrix
   import pair_pkg::*;
(
   input  logic [CLS_W-1:0] cls0,
   input  logic [CLS_W-1:0] cls1,
   input  logic             may_nul0,
   output logic             cls_ok
);
   localparam int NCODE = 1 << CLS_W;

   function automatic logic [NCODE-1:0] bit_of(input cls_e c);
      bit_of = '0;
      bit_of[c] = 1'b1;
   endfunction

   function automatic logic [NCODE-1:0] allowed_second(input logic [CLS_W-1:0] first);
      case (first)
         CL_FPOP: allowed_second = bit_of(CL_MEM) | bit_of(CL_ALU) | bit_of(CL_SHX) |
                                   bit_of(CL_NULF) | bit_of(CL_JIND) | bit_of(CL_JMP);
         CL_MEM:  allowed_second = bit_of(CL_FPOP) | bit_of(CL_ALU) | bit_of(CL_SHX) |
                                   bit_of(CL_NULF) | bit_of(CL_JMP);
         CL_ALU:  allowed_second = bit_of(CL_FPOP) | bit_of(CL_MEM) | bit_of(CL_ALU) |
                                   bit_of(CL_SHX) | bit_of(CL_NULF) | bit_of(CL_JMP) |
                                   bit_of(CL_FCHK);
         CL_SHX:  allowed_second = bit_of(CL_FPOP) | bit_of(CL_MEM) | bit_of(CL_ALU) |
                                   bit_of(CL_FCHK);
         CL_NULF: allowed_second = bit_of(CL_FPOP);
         default: allowed_second = '0;
      endcase
   endfunction

   logic [NCODE-1:0] row;
   logic             nul_ok;

   assign row    = allowed_second(cls0);
   assign nul_ok = !may_nul0 || (cls1 == CL_FPOP);
   assign cls_ok = row[cls1] && nul_ok;
endmodule

// File: rtl/pair_reg_hazard.sv
module pair_reg_hazard
   import pair_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic [CLS_W-1:0] cls0,
   input  logic [CLS_W-1:0] cls1,
   input  logic             store0,
   input  logic             store1,
   input  logic [REG_W+2:0] dst0,
   input  logic [REG_W+2:0] srca0,
   input  logic [REG_W+2:0] srcb0,
   input  logic [REG_W+2:0] dst1,
   input  logic [REG_W+2:0] srca1,
   input  logic [REG_W+2:0] srcb1,
   output logic             dep,
   output logic             fpdw
);
   localparam int OPW  = REG_W + 3;
   localparam int V_B  = REG_W + 2;
   localparam int FP_B = REG_W + 1;
   localparam int H_B  = REG_W;
   localparam int NSRC = 2;

   function automatic logic reg_hit(input logic [OPW-1:0] d, input logic [OPW-1:0] s);
      reg_hit = d[V_B] && s[V_B] && (d[REG_W-1:0] != '0) &&
                (d[FP_B] == s[FP_B]) && (d[REG_W-1:0] == s[REG_W-1:0]) &&
                (!d[FP_B] || (d[H_B] == s[H_B]));
   endfunction

   function automatic logic half_clash(input logic [OPW-1:0] ld, input logic [OPW-1:0] s);
      half_clash = ld[V_B] && s[V_B] && ld[FP_B] && s[FP_B] &&
                   (ld[REG_W-1:0] != '0) && (ld[REG_W-1:0] == s[REG_W-1:0]) &&
                   (ld[H_B] != s[H_B]);
   endfunction

   logic [OPW-1:0] src0 [NSRC];
   logic [OPW-1:0] src1 [NSRC];
   logic [NSRC-1:0] raw_hit, clash_fwd, clash_bwd;

   assign src0[0] = srca0;
   assign src0[1] = srcb0;
   assign src1[0] = srca1;
   assign src1[1] = srcb1;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign raw_hit[i]   = reg_hit(dst0, src1[i]);
      assign clash_fwd[i] = half_clash(dst0, src1[i]);
      assign clash_bwd[i] = half_clash(dst1, src0[i]);
   end

   logic flop0, flop1, fld0, fld1, st_excuse, same_tgt;

   assign flop0 = (cls0 == CL_FPOP);
   assign flop1 = (cls1 == CL_FPOP);
   assign fld0  = (cls0 == CL_MEM) && !store0 && dst0[FP_B];
   assign fld1  = (cls1 == CL_MEM) && !store1 && dst1[FP_B];

   assign st_excuse = flop0 && (cls1 == CL_MEM) && store1 && srcb1[FP_B];
   assign dep = raw_hit[0] || (raw_hit[1] && !st_excuse);

   assign same_tgt = dst0[V_B] && dst1[V_B] && dst0[FP_B] && dst1[FP_B] &&
                     (dst0[REG_W-1:0] != '0) && (dst0[H_B] == dst1[H_B]) &&
                     (dst0[REG_W-1:0] == dst1[REG_W-1:0]);

   assign fpdw = (fld0 && flop1 && (|clash_fwd)) ||
                 (flop0 && fld1 && (|clash_bwd)) ||
                 (((fld0 && flop1) || (flop0 && fld1)) && same_tgt);
endmodule

// File: rtl/pair_side_check.sv
module pair_side_check (
   input  logic odd0,
   input  logic dslot0,
   input  logic dslot1,
   input  logic tgt1,
   input  logic cb_set0,
   input  logic cb_use0,
   input  logic cb_set1,
   input  logic cb_use1,
   output logic ctx_blk,
   output logic cb_blk
);
   assign ctx_blk = odd0 || dslot0 || dslot1 || tgt1;
   assign cb_blk  = (cb_set0 && cb_use1) || (cb_set1 && cb_use0);
endmodule

// File: rtl/pair_gate.sv
module pair_gate
   import pair_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [3:0]       s0_cls,
   input  logic [REG_W+2:0] s0_dst,
   input  logic [REG_W+2:0] s0_srca,
   input  logic [REG_W+2:0] s0_srcb,
   input  logic             s0_store,
   input  logic             s0_cb_set,
   input  logic             s0_cb_use,
   input  logic             s0_may_nul,
   input  logic             s0_odd,
   input  logic             s0_dslot,
   input  logic [3:0]       s1_cls,
   input  logic [REG_W+2:0] s1_dst,
   input  logic [REG_W+2:0] s1_srca,
   input  logic [REG_W+2:0] s1_srcb,
   input  logic             s1_store,
   input  logic             s1_cb_set,
   input  logic             s1_cb_use,
   input  logic             s1_dslot,
   input  logic             s1_tgt,
   output logic             pair_ok,
   output logic [2:0]       why
);
   if (REG_W < 1 || REG_W > 16) begin : g_bad_reg_w
      initial $fatal(1, "pair_gate: REG_W must lie in 1..16");
   end
   if (CLS_W != 4) begin : g_bad_cls_w
      initial $fatal(1, "pair_gate: class code width must be 4");
   end

   logic ctx_blk, cls_ok, dep, fpdw, cb_blk;
   reason_e why_c;

   pair_side_check u_side (
      .odd0(s0_odd), .dslot0(s0_dslot), .dslot1(s1_dslot), .tgt1(s1_tgt),
      .cb_set0(s0_cb_set), .cb_use0(s0_cb_use),
      .cb_set1(s1_cb_set), .cb_use1(s1_cb_use),
      .ctx_blk(ctx_blk), .cb_blk(cb_blk)
   );

   pair_class_matrix u_cls (
      .cls0(s0_cls), .cls1(s1_cls), .may_nul0(s0_may_nul), .cls_ok(cls_ok)
   );

   pair_reg_hazard #(.REG_W(REG_W)) u_haz (
      .cls0(s0_cls), .cls1(s1_cls), .store0(s0_store), .store1(s1_store),
      .dst0(s0_dst), .srca0(s0_srca), .srcb0(s0_srcb),
      .dst1(s1_dst), .srca1(s1_srca), .srcb1(s1_srcb),
      .dep(dep), .fpdw(fpdw)
   );

   always_comb begin
      if (ctx_blk)      why_c = RS_CTX;
      else if (!cls_ok) why_c = RS_CLASS;
      else if (dep)     why_c = RS_DEP;
      else if (fpdw)    why_c = RS_FPDW;
      else if (cb_blk)  why_c = RS_CARRY;
      else              why_c = RS_NONE;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            pair_ok <= 1'b0;
            why     <= RS_NONE;
         end else begin
            pair_ok <= (why_c == RS_NONE);
            why     <= why_c;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk;
      assign pair_ok = !rst && (why_c == RS_NONE);
      assign why     = rst ? RS_NONE : why_c;
   end
endmodule

// File: rtl/pair_gate_chk.sv
module pair_gate_chk
   import pair_pkg::*;
#(
   parameter int REG_W   = 5,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic [3:0]       s0_cls,
   input logic [3:0]       s1_cls,
   input logic [REG_W+2:0] s0_dst,
   input logic             s1_srca_v,
   input logic [REG_W+2:0] s1_srcb,
   input logic             s1_store,
   input logic             s0_odd,
   input logic             s0_dslot,
   input logic             s1_dslot,
   input logic             s1_tgt,
   input logic             s0_cb_set,
   input logic             s0_cb_use,
   input logic             s1_cb_set,
   input logic             s1_cb_use,
   input logic             pair_ok,
   input logic [2:0]       why
);
   logic sys_c, ctx_c, cb_c, exc_c;
   logic sys_q, ctx_q, cb_q, exc_q;

   assign sys_c = (s0_cls == CL_SYS) || (s1_cls == CL_SYS);
   assign ctx_c = s0_odd || s0_dslot || s1_dslot || s1_tgt;
   assign cb_c  = (s0_cb_set && s1_cb_use) || (s1_cb_set && s0_cb_use);
   assign exc_c = (s0_cls == CL_FPOP) && (s1_cls == CL_MEM) && s1_store &&
                  !s1_srca_v && (s0_dst == s1_srcb);

   if (REG_OUT) begin : g_q
      always_ff @(posedge clk) begin
         if (rst) {sys_q, ctx_q, cb_q, exc_q} <= '0;
         else     {sys_q, ctx_q, cb_q, exc_q} <= {sys_c, ctx_c, cb_c, exc_c};
      end
   end else begin : g_c
      assign {sys_q, ctx_q, cb_q, exc_q} = {sys_c, ctx_c, cb_c, exc_c};
   end

   a_r1_sys_never_pairs: assert property (@(posedge clk) disable iff (rst)
      sys_q |-> !pair_ok);
   a_r10_context_blocks: assert property (@(posedge clk) disable iff (rst)
      ctx_q |-> (!pair_ok && why == RS_CTX));
   a_r9_carry_refused: assert property (@(posedge clk) disable iff (rst)
      cb_q |-> !pair_ok);
   a_r6_store_data_excused: assert property (@(posedge clk) disable iff (rst)
      exc_q |-> (why != RS_DEP));
   a_r11_ok_means_none: assert property (@(posedge clk) disable iff (rst)
      pair_ok |-> (why == RS_NONE));
   a_r12_reset_clears: assert property (@(posedge clk)
      (REG_OUT && $past(rst)) |-> (!pair_ok && why == RS_NONE));
endmodule

bind pair_gate pair_gate_chk #(.REG_W(REG_W), .REG_OUT(REG_OUT)) u_chk (
   .clk(clk), .rst(rst), .s0_cls(s0_cls), .s1_cls(s1_cls), .s0_dst(s0_dst),
   .s1_srca_v(s1_srca[REG_W+2]), .s1_srcb(s1_srcb), .s1_store(s1_store),
   .s0_odd(s0_odd), .s0_dslot(s0_dslot), .s1_dslot(s1_dslot), .s1_tgt(s1_tgt),
   .s0_cb_set(s0_cb_set), .s0_cb_use(s0_cb_use),
   .s1_cb_set(s1_cb_set), .s1_cb_use(s1_cb_use),
   .pair_ok(pair_ok), .why(why)
);

// File: tb/pair_gate_bench.sv
module pair_gate_bench;
   localparam int RW = 5;
   localparam int OW = RW + 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [3:0] s0_cls, s1_cls;
   logic [OW-1:0] s0_dst, s0_srca, s0_srcb, s1_dst, s1_srca, s1_srcb;
   logic s0_store, s0_cb_set, s0_cb_use, s0_may_nul, s0_odd, s0_dslot;
   logic s1_store, s1_cb_set, s1_cb_use, s1_dslot, s1_tgt;
   logic pair_ok;
   logic [2:0] why;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit allow [16][16];

   always #5 clk = ~clk;

   pair_gate #(.REG_W(RW), .REG_OUT(1'b1)) u_pair_gate (
      .clk(clk), .rst(rst),
      .s0_cls(s0_cls), .s0_dst(s0_dst), .s0_srca(s0_srca), .s0_srcb(s0_srcb),
      .s0_store(s0_store), .s0_cb_set(s0_cb_set), .s0_cb_use(s0_cb_use),
      .s0_may_nul(s0_may_nul), .s0_odd(s0_odd), .s0_dslot(s0_dslot),
      .s1_cls(s1_cls), .s1_dst(s1_dst), .s1_srca(s1_srca), .s1_srcb(s1_srcb),
      .s1_store(s1_store), .s1_cb_set(s1_cb_set), .s1_cb_use(s1_cb_use),
      .s1_dslot(s1_dslot), .s1_tgt(s1_tgt),
      .pair_ok(pair_ok), .why(why)
   );

   function automatic logic [OW-1:0] op(bit v, bit fp, bit h, int n);
      return {v, fp, h, RW'(n)};
   endfunction

   // operand views: [OW-1]=valid [OW-2]=fp [OW-3]=half [RW-1:0]=number
   function automatic bit reads_same(logic [OW-1:0] w, logic [OW-1:0] r);
      if (!w[OW-1] || !r[OW-1]) return 0;
      if (w[RW-1:0] == 0) return 0;
      if (w[OW-2] != r[OW-2] || w[RW-1:0] != r[RW-1:0]) return 0;
      if (w[OW-2] && (w[OW-3] != r[OW-3])) return 0;
      return 1;
   endfunction

   function automatic bit other_word(logic [OW-1:0] a, logic [OW-1:0] b);
      return a[OW-1] && b[OW-1] && a[OW-2] && b[OW-2] && a[RW-1:0] != 0 &&
             a[RW-1:0] == b[RW-1:0] && a[OW-3] != b[OW-3];
   endfunction

   function automatic int model();
      bit dep, dw, ld0, ld1;
      if (s0_odd || s0_dslot || s1_dslot || s1_tgt) return 1;
      if (!allow[s0_cls][s1_cls]) return 2;
      if (s0_may_nul && s1_cls != 0) return 2;
      dep = reads_same(s0_dst, s1_srca);
      if (reads_same(s0_dst, s1_srcb) &&
          !(s0_cls == 0 && s1_cls == 1 && s1_store && s1_srcb[OW-2])) dep = 1;
      if (dep) return 3;
      ld0 = s0_cls == 1 && !s0_store && s0_dst[OW-2];
      ld1 = s1_cls == 1 && !s1_store && s1_dst[OW-2];
      dw = 0;
      if (ld0 && s1_cls == 0) begin
         dw = other_word(s0_dst, s1_srca) || other_word(s0_dst, s1_srcb);
         if (s0_dst[OW-1] && s1_dst[OW-1] && s1_dst[OW-2] && s0_dst[RW-1:0] != 0 &&
             s0_dst[OW-3:0] == s1_dst[OW-3:0]) dw = 1;
      end
      if (ld1 && s0_cls == 0) begin
         if (other_word(s1_dst, s0_srca) || other_word(s1_dst, s0_srcb)) dw = 1;
         if (s0_dst[OW-1] && s1_dst[OW-1] && s0_dst[OW-2] && s1_dst[RW-1:0] != 0 &&
             s0_dst[OW-3:0] == s1_dst[OW-3:0]) dw = 1;
      end
      if (dw) return 4;
      if ((s0_cb_set && s1_cb_use) || (s1_cb_set && s0_cb_use)) return 5;
      return 0;
   endfunction

   task automatic clear();
      s0_cls = 4'd2; s1_cls = 4'd2;
      s0_dst = '0; s0_srca = '0; s0_srcb = '0;
      s1_dst = '0; s1_srca = '0; s1_srcb = '0;
      {s0_store, s0_cb_set, s0_cb_use, s0_may_nul, s0_odd, s0_dslot} = '0;
      {s1_store, s1_cb_set, s1_cb_use, s1_dslot, s1_tgt} = '0;
   endtask

   task automatic compare(string tag, bit eo, int ew);
      checks++;
      if (pair_ok !== eo || why !== 3'(ew)) begin
         errors++;
         $display("FAIL %s: pair_ok=%0b why=%0d expected pair_ok=%0b why=%0d",
                  tag, pair_ok, why, eo, ew);
      end
   endtask

   task automatic step(string tag);
      int ew;
      bit eo;
      ew = rst ? 0 : model();
      eo = !rst && ew == 0;
      @(posedge clk);
      #1;
      compare(tag, eo, ew);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      foreach (allow[f, s]) allow[f][s] = 0;
      allow[0][1]=1; allow[0][2]=1; allow[0][3]=1; allow[0][4]=1; allow[0][5]=1; allow[0][6]=1;
      allow[1][0]=1; allow[1][2]=1; allow[1][3]=1; allow[1][4]=1; allow[1][6]=1;
      allow[2][0]=1; allow[2][1]=1; allow[2][2]=1; allow[2][3]=1; allow[2][4]=1;
      allow[2][6]=1; allow[2][7]=1;
      allow[3][0]=1; allow[3][1]=1; allow[3][2]=1; allow[3][7]=1;
      allow[4][0]=1;

      clear();
      repeat (3) @(posedge clk);
      #1;
      compare("R12 reset state", 0, 0);
      rst = 0;

      clear(); step("R3 alu+alu");
      clear(); s0_cls = 0; s1_cls = 5; step("R2 fpop+jind");
      clear(); s0_cls = 1; s1_cls = 5; step("R2 mem+jind");
      clear(); s0_cls = 1; s1_cls = 0; step("R2 mem+fpop");
      clear(); s0_cls = 3; s1_cls = 6; step("R3 shx+jmp");
      clear(); s0_cls = 3; s1_cls = 7; step("R3 shx+fchk");
      clear(); s0_cls = 4; s1_cls = 0; step("R3 nulf+fpop");
      clear(); s0_cls = 4; s1_cls = 2; step("R3 nulf+alu");
      clear(); s0_cls = 6; s1_cls = 0; step("R3 jmp first");
      clear(); s0_cls = 2; s1_cls = 8; step("R1 sys second");
      clear(); s0_cls = 8; s1_cls = 0; step("R1 sys first");
      clear(); s0_cls = 12; s1_cls = 2; step("R1 unused code");
      clear(); s0_may_nul = 1; step("R4 may_nul alu+alu");
      clear(); s0_may_nul = 1; s1_cls = 0; step("R4 may_nul alu+fpop");
      clear(); s0_dst = op(1,0,0,5); s1_srca = op(1,0,0,5); step("R5 int raw");
      clear(); s0_dst = op(1,0,0,0); s1_srca = op(1,0,0,0); step("R5 r0 dest");
      clear(); s0_dst = op(0,0,0,5); s1_srcb = op(1,0,0,5); step("R5 invalid dest");
      clear(); s0_dst = op(1,1,0,5); s1_srcb = op(1,1,1,5); step("R5 fp other half");
      clear(); s0_dst = op(1,1,0,5); s1_srcb = op(1,0,0,5); step("R5 other file");
      clear(); s0_cls = 0; s1_cls = 1; s1_store = 1;
      s0_dst = op(1,1,0,4); s1_srcb = op(1,1,0,4); step("R6 fp store data");
      clear(); s0_cls = 0; s1_cls = 1; s1_store = 1;
      s0_dst = op(1,1,0,4); s1_srca = op(1,1,0,4); step("R6 store base");
      clear(); s0_cls = 1; s1_cls = 0; s0_dst = op(1,1,0,6); s1_srca = op(1,1,1,6);
      step("R7 load then fpop");
      clear(); s0_cls = 0; s1_cls = 1; s1_dst = op(1,1,1,6); s0_srcb = op(1,1,0,6);
      step("R7 fpop then load");
      clear(); s0_cls = 0; s1_cls = 1; s0_dst = op(1,1,1,3); s1_dst = op(1,1,1,3);
      step("R8 same target");
      clear(); s0_cls = 0; s1_cls = 1; s0_dst = op(1,1,1,3); s1_dst = op(1,1,0,3);
      step("R8 other half target");
      clear(); s0_cb_set = 1; s1_cb_use = 1; step("R9 set then use");
      clear(); s1_cb_set = 1; s0_cb_use = 1; step("R9 use then set");
      clear(); s0_cb_set = 1; s1_cb_set = 1; step("R9 both set");
      clear(); s0_odd = 1; step("R10 odd first");
      clear(); s0_dslot = 1; step("R10 slot0 delay");
      clear(); s1_dslot = 1; step("R10 slot1 delay");
      clear(); s1_tgt = 1; step("R10 slot1 target");
      clear(); s0_odd = 1; s1_cls = 8; step("R11 ctx over class");
      clear(); s1_cls = 8; s0_dst = op(1,0,0,2); s1_srca = op(1,0,0,2);
      step("R11 class over dep");
      clear(); s0_dst = op(1,0,0,2); s1_srca = op(1,0,0,2); s0_cb_set = 1; s1_cb_use = 1;
      step("R11 dep over carry");
      clear(); rst = 1; step("R12 mid reset");
      rst = 0;

      for (int n = 0; n < 2000; n++) begin
         s0_cls = 4'($urandom_range(0, 9));
         s1_cls = 4'($urandom_range(0, 9));
         s0_dst = op($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,3));
         s0_srca = op($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,3));
         s0_srcb = op($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,3));
         s1_dst = op($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,3));
         s1_srca = op($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,3));
         s1_srcb = op($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,3));
         s0_store = 1'($urandom_range(0,1));
         s1_store = 1'($urandom_range(0,1));
         s0_cb_set = ($urandom_range(0,3) == 0);
         s0_cb_use = ($urandom_range(0,3) == 0);
         s1_cb_set = ($urandom_range(0,3) == 0);
         s1_cb_use = ($urandom_range(0,3) == 0);
         s0_may_nul = ($urandom_range(0,7) == 0);
         s0_odd = ($urandom_range(0,9) == 0);
         s0_dslot = ($urandom_range(0,9) == 0);
         s1_dslot = ($urandom_range(0,9) == 0);
         s1_tgt = ($urandom_range(0,9) == 0);
         rst = ($urandom_range(0,63) == 0);
         step("R12 random stream");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule